// File: doc/BRIEF.md
# Signed Integer to Double Converter

This block turns a two's-complement integer into an IEEE 754 binary64 value and places it in the low half of a 128-bit vector register image. The upper half of that image is carried through untouched, so the caller supplies the current destination contents with each request and gets back the merged image.

Two operand sizes exist. The narrow form reads only the low 32 bits of the source word and is always accepted. The wide form reads all 64 bits. It is accepted only while the long-mode flag is high. A wide request made without that flag is refused: the illegal flag goes high and the destination comes back unchanged. Narrow values always fit the 53-bit significand exactly. A wide value with more significant bits than that is rounded to nearest, ties to even, and the inexact flag is raised.

The result is registered and appears exactly one clock after the request strobe, together with a one-cycle valid pulse.

Top module: `sint_to_f64_merge`

## Requirements
- R1: With `wide_op` low, only `src_word[31:0]` is converted, read as a signed 32-bit value. `src_word[63:32]` has no effect. This form is accepted whether `long_mode` is high or low.
- R2: With `wide_op` and `long_mode` both high, all 64 bits of `src_word` are converted, read as a signed 64-bit value.
- R3: The result goes to `dest_out[63:0]` in binary64 layout: sign in bit 63, biased exponent in bits 62:52 (1023 plus the position of the leading one of the magnitude), fraction in bits 51:0 (the bits below the leading one, left-aligned).
- R4: For every accepted request, `dest_out[127:64]` equals `dest_in[127:64]` of that request.
- R5: With `wide_op` high and `long_mode` low, `illegal` is 1, `inexact` is 0 and `dest_out` equals the whole `dest_in` of that request.
- R6: A zero source gives +0.0, with `dest_out[63:0]` all clear.
- R7: A negative source sets bit 63 and converts its magnitude. The wide source 0x8000000000000000 gives exactly 0xC3E0000000000000.
- R8: A wide source whose magnitude has more than 53 significant bits is rounded to nearest, ties to even, and `inexact` is 1. Otherwise `inexact` is 0, which includes every narrow request.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. `illegal` and `inexact` are low in any cycle where `out_valid` is low.
- R10: During and right after synchronous reset, `out_valid`, `illegal`, `inexact` and `dest_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| src_word | input | 64 | Integer source operand |
| wide_op | input | 1 | 1 selects the 64-bit operand form, 0 the 32-bit form |
| long_mode | input | 1 | 1 when 64-bit operation is permitted |
| dest_in | input | 128 | Current destination register image |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| dest_out | output | 128 | Updated destination register image |
| illegal | output | 1 | Wide form requested without long mode |
| inexact | output | 1 | Rounding discarded nonzero bits |

## Verification
Directed cases cover the values where conversion logic usually breaks. Zero and minus one check the magnitude path. The most negative values of both widths check that negation of the extreme value does not overflow. Narrow sources with junk in the upper source bits check that those bits are really ignored. The wide sources 2^53+1, 2^53+3 and 2^63-1 separate a correct ties-to-even decision, with its carry into the exponent, from truncation or round-half-up. Random sources drawn at many bit widths, in both operand forms and both mode settings, are compared against a reference built on the simulator's own integer-to-real conversion. The random runs also cover refused requests, where the upper destination half and the illegal flag tell a correct merge from a full overwrite.

// File: rtl/i2d_pkg.sv
package i2d_pkg;
    localparam int SRC_W    = 64;
    localparam int NARROW_W = 32;
    localparam int VEC_W    = 128;
    localparam int FRAC_W   = 52;
    localparam int EXP_W    = 11;
    localparam int EXP_BIAS = 1023;
    localparam int POS_W    = $clog2(SRC_W);
    localparam int LOW_W    = SRC_W - 1 - FRAC_W;   // bits below the kept fraction

    typedef struct packed {
        logic             neg;
        logic             legal;
        logic [SRC_W-1:0] mag;
    } operand_t;

    typedef struct packed {
        logic             neg;
        logic             zero;
        logic [POS_W-1:0] lead;
        logic [SRC_W-1:0] norm;   // leading one sits at the top bit
    } norm_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } f64_t;

    // Index of the highest set bit; zero for a zero input.
    function automatic logic [POS_W-1:0] find_lead(input logic [SRC_W-1:0] v);
        logic [POS_W-1:0] pos;
        pos = '0;
        for (int i = 0; i < SRC_W; i++) begin
            if (v[i]) pos = POS_W'(i);
        end
        return pos;
    endfunction
endpackage

// File: rtl/i2d_operand_prep.sv
module i2d_operand_prep
    import i2d_pkg::*;
#(
    parameter int W  = SRC_W,
    parameter int NW = NARROW_W
) (
    input  logic [W-1:0] src,
    input  logic         wide,
    input  logic         long_mode,
    output operand_t     opnd
);
    logic [W-1:0] chosen;
    logic         use_full;

    assign use_full = wide & long_mode;

    generate
        if (NW < W) begin : g_sext
            assign chosen = use_full ? src : {{(W-NW){src[NW-1]}}, src[NW-1:0]};
        end else begin : g_full
            assign chosen = src;
        end
    endgenerate

    always_comb begin
        opnd.neg   = chosen[W-1];
        opnd.legal = ~(wide & ~long_mode);
        opnd.mag   = chosen[W-1] ? (~chosen + W'(1)) : chosen;
    end
endmodule

// File: rtl/i2d_normalize.sv
module i2d_normalize
    import i2d_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  operand_t opnd,
    output norm_t    nrm
);
    logic [POS_W-1:0] lead;
    logic [POS_W-1:0] shamt;

    assign lead  = find_lead(opnd.mag);
    assign shamt = POS_W'(W - 1) - lead;

    always_comb begin
        nrm.neg  = opnd.neg;
        nrm.zero = (opnd.mag == '0);
        nrm.lead = lead;
        nrm.norm = opnd.mag << shamt;
    end
endmodule

// File: rtl/i2d_round_pack.sv
module i2d_round_pack
    import i2d_pkg::*;
#(
    parameter int W  = SRC_W,
    parameter int FW = FRAC_W,
    parameter int LW = LOW_W
) (
    input  norm_t nrm,
    output f64_t  res,
    output logic  lost
);
    logic [FW-1:0] kept;
    logic          guard;
    logic          sticky;
    logic          bump;
    logic [FW:0]   summed;

    assign kept   = nrm.norm[W-2 -: FW];
    assign guard  = nrm.norm[LW-1];
    assign sticky = |nrm.norm[LW-2:0];
    assign bump   = guard & (sticky | kept[0]);
    assign summed = {1'b0, kept} + (FW+1)'(bump);
    assign lost   = guard | sticky;

    always_comb begin
        if (nrm.zero) begin
            res = '0;
        end else begin
            res.sign = nrm.neg;
            res.exp  = EXP_W'(EXP_BIAS) + EXP_W'(nrm.lead) + EXP_W'(summed[FW]);
            res.frac = summed[FW-1:0];
        end
    end
endmodule

// File: rtl/sint_to_f64_merge.sv
module sint_to_f64_merge
    import i2d_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] src_word,
    input  logic             wide_op,
    input  logic             long_mode,
    input  logic [VEC_W-1:0] dest_in,
    output logic             out_valid,
    output logic [VEC_W-1:0] dest_out,
    output logic             illegal,
    output logic             inexact
);
    localparam int HALF = VEC_W / 2;

    operand_t opnd;
    norm_t    nrm;
    f64_t     res;
    logic     lost;

    i2d_operand_prep u_prep (
        .src       (src_word),
        .wide      (wide_op),
        .long_mode (long_mode),
        .opnd      (opnd)
    );

    i2d_normalize u_norm (
        .opnd (opnd),
        .nrm  (nrm)
    );

    i2d_round_pack u_round (
        .nrm  (nrm),
        .res  (res),
        .lost (lost)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            inexact   <= 1'b0;
            dest_out  <= '0;
        end else begin
            out_valid <= in_valid;
            illegal   <= in_valid & ~opnd.legal;
            inexact   <= in_valid & opnd.legal & lost;
            if (in_valid) begin
                if (opnd.legal) dest_out <= {dest_in[VEC_W-1:HALF], res};
                else            dest_out <= dest_in;
            end
        end
    end
endmodule

// File: rtl/sint_to_f64_merge_checker.sv
module sint_to_f64_merge_checker
    import i2d_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [SRC_W-1:0] src_word,
    input logic             wide_op,
    input logic             long_mode,
    input logic [VEC_W-1:0] dest_in,
    input logic             out_valid,
    input logic [VEC_W-1:0] dest_out,
    input logic             illegal,
    input logic             inexact
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !illegal && !inexact));

    a_r4_upper_kept: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> dest_out[VEC_W-1:VEC_W/2] == $past(dest_in[VEC_W-1:VEC_W/2]));

    a_r5_refused: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_op && !long_mode) |=>
            (illegal && !inexact && dest_out == $past(dest_in)));

    a_r1_narrow_accepted: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_op) |=> !illegal);

    a_r8_narrow_exact: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_op) |=> !inexact);

    a_r6_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_op && src_word[NARROW_W-1:0] == '0) |=> dest_out[63:0] == '0);

    a_r7_sign: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_op && src_word[NARROW_W-1]) |=> dest_out[63]);
endmodule

bind sint_to_f64_merge sint_to_f64_merge_checker chk (.*);

// File: tb/sint_to_f64_merge_test.sv
module sint_to_f64_merge_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [63:0]  src_word;
    logic         wide_op;
    logic         long_mode;
    logic [127:0] dest_in;
    logic         out_valid;
    logic [127:0] dest_out;
    logic         illegal;
    logic         inexact;

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    sint_to_f64_merge uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_word(src_word),
        .wide_op(wide_op), .long_mode(long_mode), .dest_in(dest_in),
        .out_valid(out_valid), .dest_out(dest_out), .illegal(illegal), .inexact(inexact)
    );

    function automatic logic [63:0] eff_src(input logic [63:0] s, input bit w, input bit l);
        return (w && l) ? s : {{32{s[31]}}, s[31:0]};
    endfunction

    function automatic logic [63:0] ref_bits(input logic [63:0] v);
        longint sv;
        real    r;
        sv = longint'(v);
        r  = sv;
        return $realtobits(r);
    endfunction

    function automatic bit ref_inexact(input logic [63:0] v);
        logic [63:0] m;
        int p;
        m = v[63] ? (~v + 64'd1) : v;
        p = -1;
        for (int i = 0; i < 64; i++) if (m[i]) p = i;
        if (p <= 52) return 1'b0;
        return |(m & ((64'd1 << (p - 52)) - 64'd1));
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] s, input bit w, input bit l,
                         input logic [127:0] d, input string tag);
        logic [63:0]  v;
        logic [127:0] exp_d;
        bit           bad_req;
        @(negedge clk);
        in_valid = 1'b1; src_word = s; wide_op = w; long_mode = l; dest_in = d;
        @(negedge clk);
        in_valid = 1'b0; src_word = $urandom; dest_in = {$urandom, $urandom, $urandom, $urandom};
        bad_req = w && !l;
        v = eff_src(s, w, l);
        exp_d = bad_req ? d : {d[127:64], ref_bits(v)};
        check({tag, " R9 out_valid"}, 128'(out_valid), 128'd1);
        check({tag, " R3 R4 R5 dest_out"}, dest_out, exp_d);
        check({tag, " R5 illegal"}, 128'(illegal), 128'(bad_req));
        check({tag, " R8 inexact"}, 128'(inexact), bad_req ? 128'd0 : 128'(ref_inexact(v)));
    endtask

    task automatic expect_f64(input logic [63:0] s, input bit w, input logic [63:0] bits,
                              input bit inx, input string tag);
        logic [127:0] d;
        d = {$urandom, $urandom, $urandom, $urandom};
        apply(s, w, 1'b1, d, tag);
        check({tag, " literal"}, dest_out, {d[127:64], bits});
        check({tag, " literal inexact"}, 128'(inexact), 128'(inx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; in_valid = 1'b0; src_word = '1; wide_op = 1'b1; long_mode = 1'b1; dest_in = '1;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid", 128'(out_valid), 128'd0);
        check("R10 illegal", 128'(illegal), 128'd0);
        check("R10 inexact", 128'(inexact), 128'd0);
        check("R10 dest_out", dest_out, 128'd0);
        rst = 1'b0;

        // directed corners
        expect_f64(64'h0, 1'b0, 64'h0, 1'b0, "R6 zero narrow");
        expect_f64(64'h0, 1'b1, 64'h0, 1'b0, "R6 zero wide");
        expect_f64(64'hFFFF_FFFF_0000_0000, 1'b0, 64'h0, 1'b0, "R1 upper junk zero");
        expect_f64(64'h1234_5678_FFFF_FFFF, 1'b0, 64'hBFF0_0000_0000_0000, 1'b0, "R1 R7 minus one");
        expect_f64(64'h0000_0000_8000_0000, 1'b0, 64'hC1E0_0000_0000_0000, 1'b0, "R7 narrow min");
        expect_f64(64'h0000_0000_7FFF_FFFF, 1'b0, 64'h41DF_FFFF_FFC0_0000, 1'b0, "R1 narrow max");
        expect_f64(64'h8000_0000_0000_0000, 1'b1, 64'hC3E0_0000_0000_0000, 1'b0, "R7 wide min");
        expect_f64(64'h0020_0000_0000_0001, 1'b1, 64'h4340_0000_0000_0000, 1'b1, "R8 tie to even down");
        expect_f64(64'h0020_0000_0000_0003, 1'b1, 64'h4340_0000_0000_0002, 1'b1, "R8 tie to even up");
        expect_f64(64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 64'h43E0_0000_0000_0000, 1'b1, "R8 carry into exponent");
        expect_f64(64'h001F_FFFF_FFFF_FFFF, 1'b1, 64'h433F_FFFF_FFFF_FFFF, 1'b0, "R2 53 bits exact");
        expect_f64(64'h0000_0001_0000_0000, 1'b1, 64'h41F0_0000_0000_0000, 1'b0, "R2 wide 2^32");
        apply(64'h0000_0001_0000_0000, 1'b1, 1'b0, {64'hAAAA_5555_AAAA_5555, 64'h0123_4567_89AB_CDEF}, "R5 refused");
        apply(64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 1'b0, {64'h1111_2222_3333_4444, 64'h5}, "R1 narrow outside long mode");

        // idle cycle after a request: R9
        @(negedge clk);
        check("R9 idle out_valid", 128'(out_valid), 128'd0);
        check("R9 idle illegal", 128'(illegal), 128'd0);
        check("R9 idle inexact", 128'(inexact), 128'd0);

        // random vectors at many widths
        for (int k = 0; k < 600; k++) begin
            logic [63:0] s;
            int          sh;
            sh = $urandom_range(63, 0);
            s  = {$urandom, $urandom};
            s  = $signed(s) >>> sh;
            apply(s, 1'($urandom), 1'($urandom_range(3, 0) != 0),
                  {$urandom, $urandom, $urandom, $urandom}, "R1 R2 R3 R8 random");
            if ((k % 7) == 0) begin
                @(negedge clk);
                check("R9 random idle", 128'(out_valid), 128'd0);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule